// File: doc/BRIEF.md
# Dual-Mode Serial Streamer

This block gives a 128-byte configuration memory its power-up personality. After reset it sits in a transmit-only mode. It counts a silent synchronization phase on a dedicated slow stream clock. It then pushes the whole memory out as a serial bit stream on an open-drain data line, one byte after another, wrapping from the top address back to zero for as long as the stream clock runs.

A second clock input, which belongs to a bidirectional two-wire protocol engine outside this block, is watched all the time. The first qualified low-going transition on that input moves the block permanently into bidirectional mode. In that mode it releases the data line and ignores the stream clock. Only a reset returns it to transmit-only mode.

Both clock inputs are asynchronous to the system clock `clk` and are synchronized inside the block. Memory bytes are fetched over a request/response port. A request (`mem_req_valid` with `mem_req_addr`) is held until `mem_req_ready` accepts it, so the memory may apply back-pressure. The memory must accept the request and return the byte (`mem_rsp_valid`, `mem_rsp_data`) before the stream clock's next rising edge after the request. The block cannot stall the external stream clock.

Top module: `dual_mode_streamer`

## Requirements
- R1: During and directly after reset, `bidir_mode` is 0, the line is released (`sda_oe`=0, `sda_dat`=1), and a memory request for address 0 is pending (`mem_req_valid`=1, `mem_req_addr`=0).
- R2: The first nine rising edges of `vclk_in` leave the line released. The tenth rising edge drives bit 7 of the byte at address 0.
- R3: In a data slot, each rising edge of `vclk_in` drives the next bit of the current byte, most significant bit first, with `sda_dat` equal to the bit and `sda_oe`=1 exactly when the bit is 0. If `vclk_in` is first sampled high at `clk` edge k, the outputs change at edge k+2.
- R4: The rising edge after the eighth bit of every byte is a gap slot in which the line is released.
- R5: Bytes follow in ascending address order. After address 127 the next byte is address 0, with the same nine-edge byte rhythm and no extra slot.
- R6: A memory request, once raised, keeps `mem_req_valid`=1 and a stable `mem_req_addr` until a cycle with `mem_req_ready`=1. Exactly one request is issued per byte, and successive requests carry successive addresses modulo 128.
- R7: `bidir_mode` becomes 1 only after `bclk_in` has been sampled low at SPIKE_CYC (25) consecutive `clk` edges, taking effect SPIKE_CYC+1 edges after the first low sample. A low pulse sampled at fewer consecutive edges has no effect on the mode or the stream.
- R8: Once `bidir_mode` is 1 it stays 1 until reset. The line stays released, `vclk_in` edges have no effect, and no new memory request is raised.
- R9: When a `vclk_in` rising edge and mode entry are processed at the same `clk` edge, mode entry wins. The line stays released and no bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vclk_in | input | 1 | Stream clock for transmit-only mode, asynchronous |
| bclk_in | input | 1 | Bidirectional-mode clock, watched for the mode switch, asynchronous |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 7 | Address of the requested byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| sda_dat | output | 1 | Current bit value, 1 when the line is released |
| bidir_mode | output | 1 | 1 once bidirectional mode has been entered |

## Verification
The stream sequencer and the mode latch can both act at the same `clk` edge: a synchronized `vclk_in` rise and the 25th consecutive low sample of `bclk_in`. The bench provokes this by lowering `bclk_in` and raising `vclk_in` exactly SPIKE_CYC-1 cycles later. It times this to land on a data slot whose bit is 0, so a design that let the stream win would pull the line low. A cycle-level reference model predicts the released line and the set mode flag on every clock. The bench also checks that no further memory request appears.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // Phase of the transmit-only bit sequencer.
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,   // silent synchronization edges after reset
    PH_DATA = 2'd1,   // shifting out the bits of a byte
    PH_GAP  = 2'd2    // released slot after each byte
  } phase_e;
endpackage

// File: rtl/dms_sync.sv
// Multi-stage synchronizer for an asynchronous level into the clk domain.
module dms_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dms_spike_filter.sv
// Level filter: the filtered level follows the input only after the input
// has differed for SPIKE_CYC consecutive cycles. fall_qual marks the cycle
// in which the filtered level goes from high to low.
module dms_spike_filter #(
  parameter int SPIKE_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall_qual
);
  localparam int CW = $clog2(SPIKE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(SPIKE_CYC - 1);

  logic          flt;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt <= 1'b1;
      run <= '0;
    end else if (lvl == flt) begin
      run <= '0;
    end else if (run == LIM) begin
      flt <= lvl;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign fall_qual = flt & ~lvl & (run == LIM);
endmodule

// File: rtl/dms_byte_fetch.sv
// Issues one memory read per byte with a valid/ready request and holds the
// returned byte for the sequencer. The first request (address 0) is raised
// straight out of reset.
module dms_byte_fetch #(
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic [BYTE_W-1:0] byte_buf
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] nxt_addr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b1;
      req_addr  <= '0;
      nxt_addr  <= bump('0);
    end else if (fetch && (!req_valid || req_ready)) begin
      req_valid <= 1'b1;
      req_addr  <= nxt_addr;
      nxt_addr  <= bump(nxt_addr);
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         byte_buf <= '0;
    else if (rsp_valid) byte_buf <= rsp_data;
  end
endmodule

// File: rtl/dms_bit_seq.sv
// Transmit-only bit sequencer: silent sync edges, then bytes MSB first,
// each followed by a released gap slot that also triggers the next fetch.
module dms_bit_seq
  import dms_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SYNC_EDGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vrise,
  input  logic              halt,
  input  logic [BYTE_W-1:0] next_byte,
  output logic              fetch,
  output logic              sda_oe,
  output logic              sda_dat
);
  localparam int CNT_MAX = (SYNC_EDGES > BYTE_W) ? SYNC_EDGES : BYTE_W;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_EDGES - 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BYTE_W - 1);

  phase_e            phase;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg;
  logic              cur_bit;

  // First bit comes straight from the prefetched byte; the rest from shreg.
  assign cur_bit = (cnt == '0) ? next_byte[BYTE_W-1] : shreg[BYTE_W-1];
  assign fetch   = vrise & ~halt & (phase == PH_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_SYNC;
      cnt     <= '0;
      shreg   <= '0;
      sda_oe  <= 1'b0;
      sda_dat <= 1'b1;
    end else if (halt) begin
      sda_oe  <= 1'b0;
      sda_dat <= 1'b1;
    end else if (vrise) begin
      unique case (phase)
        PH_SYNC: begin
          sda_oe  <= 1'b0;
          sda_dat <= 1'b1;
          if (cnt == SYNC_LAST) begin
            phase <= PH_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          sda_dat <= cur_bit;
          sda_oe  <= ~cur_bit;
          if (cnt == '0) shreg <= {next_byte[BYTE_W-2:0], 1'b0};
          else           shreg <= {shreg[BYTE_W-2:0], 1'b0};
          if (cnt == BIT_LAST) begin
            phase <= PH_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GAP: begin
          sda_oe  <= 1'b0;
          sda_dat <= 1'b1;
          phase   <= PH_DATA;
          cnt     <= '0;
        end
        default: begin
          phase <= PH_SYNC;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dual_mode_streamer.sv
module dual_mode_streamer
  import dms_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int BYTE_W      = 8,
  parameter int SYNC_EDGES  = 9,
  parameter int SPIKE_CYC   = 25,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(DEPTH)  // derived, keep default
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              bclk_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              sda_oe,
  output logic              sda_dat,
  output logic              bidir_mode
);
  logic              vclk_lvl;
  logic              vclk_prev;
  logic              vclk_rise;
  logic              bclk_lvl;
  logic              fall_qual;
  logic              halt;
  logic              fetch;
  logic [BYTE_W-1:0] byte_buf;

  // Stream clock: synchronize, then detect the rising edge.
  dms_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_vsync (
    .clk(clk), .rst_n(rst_n), .d(vclk_in), .q(vclk_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vclk_prev <= 1'b0;
    else        vclk_prev <= vclk_lvl;
  end

  assign vclk_rise = vclk_lvl & ~vclk_prev;

  // Bidirectional clock: synchronize and filter spikes.
  dms_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_bsync (
    .clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bclk_lvl)
  );

  dms_spike_filter #(.SPIKE_CYC(SPIKE_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl(bclk_lvl), .fall_qual(fall_qual)
  );

  // One-way mode latch; entry takes priority over the stream in its cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bidir_mode <= 1'b0;
    else        bidir_mode <= bidir_mode | fall_qual;
  end

  assign halt = bidir_mode | fall_qual;

  dms_byte_fetch #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .AW(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch(fetch),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .byte_buf(byte_buf)
  );

  dms_bit_seq #(.BYTE_W(BYTE_W), .SYNC_EDGES(SYNC_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .vrise(vclk_rise), .halt(halt),
    .next_byte(byte_buf), .fetch(fetch), .sda_oe(sda_oe), .sda_dat(sda_dat)
  );
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          sda_dat,
  input logic          bidir_mode,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          bclk_lvl,
  input logic          vclk_rise,
  input logic          fall_qual,
  input logic          fetch
);
  // R3: the line is only pulled low for a 0 bit
  a_r3_pull_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_dat);

  // R4: the gap slot that starts a fetch leaves the line released
  a_r4_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> !sda_oe);

  // R6: a waiting request holds valid and address
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7: mode entry only follows a low synchronized level
  a_r7_entry_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bidir_mode) |-> $past(!bclk_lvl));

  // R8: mode is sticky
  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |=> bidir_mode);

  // R8: line released in bidirectional mode
  a_r8_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !sda_oe);

  // R8: no new request once in bidirectional mode
  a_r8_no_new_req: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode && !mem_req_valid |=> !mem_req_valid);

  // R9: collision of stream edge and mode entry resolves to the mode
  a_r9_mode_wins: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_rise && fall_qual |=> bidir_mode && !sda_oe);
endmodule

bind dual_mode_streamer dms_checker #(.AW(ADDR_W)) u_chk (.*);

// File: tb/dual_mode_streamer_bench.sv
module dual_mode_streamer_bench;
  localparam int DEPTH = 128;
  localparam int SPIKE = 25;
  localparam int SYNCE = 9;
  localparam int HALF  = 6;

  // 250 MHz: 4 time-unit period
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, vclk_in, bclk_in, mem_req_ready, mem_rsp_valid;
  logic [7:0] mem_rsp_data;
  logic       mem_req_valid;
  logic [6:0] mem_req_addr;
  logic       sda_oe, sda_dat, bidir_mode;

  dual_mode_streamer u_dual_mode_streamer (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .bclk_in(bclk_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .sda_oe(sda_oe), .sda_dat(sda_dat),
    .bidir_mode(bidir_mode)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic [7:0] mem [DEPTH];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model (updated on every posedge) ----------------
  bit    q1v, q2v, q3v, q1b, q2b;
  bit    m_oe, m_dat, m_mode, m_flt, mrise, msetm;
  int    m_edges, m_run, mk, mslot, midx, ma;
  string m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      q1v = 0; q2v = 0; q3v = 0; q1b = 1; q2b = 1;
      m_edges = 0; m_run = 0; m_oe = 0; m_dat = 1; m_mode = 0; m_flt = 1;
      m_tag = "R1";
    end else begin
      mrise = q2v && !q3v;
      msetm = 0;
      if (q2b == m_flt) m_run = 0;
      else if (m_run == SPIKE - 1) begin
        m_flt = q2b; m_run = 0;
        if (!q2b) msetm = 1;
      end else m_run++;
      if (m_mode || msetm) begin
        m_tag = (mrise && msetm) ? "R9" : "R8";
        m_mode = 1; m_oe = 0; m_dat = 1;
      end else if (mrise) begin
        m_edges++;
        if (m_edges <= SYNCE) begin
          m_oe = 0; m_dat = 1; m_tag = "R2";
        end else begin
          mk = m_edges - SYNCE - 1;
          mslot = mk % 9;
          midx = mk / 9;
          ma = midx % DEPTH;
          if (mslot < 8) begin
            m_dat = mem[ma][7 - mslot];
            m_oe = !m_dat;
            m_tag = (midx >= DEPTH && ma < 2) ? "R5" : ((mk == 0) ? "R2" : "R3");
          end else begin
            m_oe = 0; m_dat = 1; m_tag = "R4";
          end
        end
      end
      q3v = q2v; q2v = q1v; q1v = vclk_in;
      q2b = q1b; q1b = bclk_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sda_oe == m_oe, m_tag, "sda_oe", sda_oe, m_oe);
      check(sda_dat == m_dat, m_tag, "sda_dat", sda_dat, m_dat);
      check(bidir_mode == m_mode, "R7", "bidir_mode", bidir_mode, m_mode);
    end
  end

  // ---------------- memory with back-pressure, driven at negedge ----------------
  int         rdy_phase, acc_cnt;
  bit         pend, was_wait, prev_v;
  logic [6:0] pend_addr, wait_addr;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
      rdy_phase = 0; acc_cnt = 0; pend = 0; was_wait = 0; prev_v = 0;
      pend_addr = 0; wait_addr = 0;
    end else begin
      mem_rsp_valid = pend;
      mem_rsp_data  = mem[pend_addr];
      if (was_wait) begin
        check(mem_req_valid == 1'b1, "R6", "valid held while waiting", mem_req_valid, 1);
        check(mem_req_addr == wait_addr, "R6", "address held while waiting",
              mem_req_addr, wait_addr);
      end
      if (mem_req_valid && !prev_v && bidir_mode)
        check(0, "R8", "new request after mode entry", 1, 0);
      rdy_phase++;
      mem_req_ready = (rdy_phase % 3) != 0;
      pend = mem_req_valid && mem_req_ready;
      if (pend) begin
        check(int'(mem_req_addr) == acc_cnt % DEPTH, (acc_cnt >= DEPTH) ? "R5" : "R6",
              "request address", mem_req_addr, acc_cnt % DEPTH);
        pend_addr = mem_req_addr;
        acc_cnt++;
      end
      was_wait  = mem_req_valid && !mem_req_ready;
      wait_addr = mem_req_addr;
      prev_v    = mem_req_valid;
    end
  end

  // ---------------- stimulus ----------------
  task automatic vclk_pulse();
    vclk_in = 1;
    repeat (HALF) @(negedge clk);
    vclk_in = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bclk_glitch(input int len);
    bclk_in = 0;
    repeat (len) @(negedge clk);
    bclk_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_and_check();
    rst_n = 0; vclk_in = 0; bclk_in = 1;
    repeat (5) @(negedge clk);
    check(bidir_mode == 0, "R1", "reset mode", bidir_mode, 0);
    check(sda_oe == 0, "R1", "reset sda_oe", sda_oe, 0);
    check(sda_dat == 1, "R1", "reset sda_dat", sda_dat, 1);
    check(mem_req_valid == 1, "R1", "reset request valid", mem_req_valid, 1);
    check(mem_req_addr == 0, "R1", "reset request address", mem_req_addr, 0);
    rst_n = 1;
  endtask

  int acc_before;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 53 + 17);
    @(negedge clk);
    reset_and_check();

    // Full stream past the wrap, with short bclk pulses that must be ignored.
    for (int i = 0; i < SYNCE + 130 * 9; i++) begin
      vclk_pulse();
      if (i == 40)  bclk_glitch(10);
      if (i == 300) bclk_glitch(SPIKE - 1);
    end
    check(bidir_mode == 0, "R7", "short bclk pulses ignored", bidir_mode, 0);
    check(acc_cnt >= DEPTH + 2, "R5", "requests past the wrap", acc_cnt, DEPTH + 2);

    // Collision: mode entry lands on the same edge as a 0-valued data bit.
    bclk_in = 0;
    repeat (SPIKE - 1) @(negedge clk);
    vclk_in = 1;
    repeat (4) @(negedge clk);
    check(bidir_mode == 1, "R9", "mode set on collision", bidir_mode, 1);
    check(sda_oe == 0, "R9", "line released on collision", sda_oe, 0);
    repeat (HALF) @(negedge clk);
    vclk_in = 0; bclk_in = 1;
    repeat (HALF) @(negedge clk);

    // Stream clock ignored in bidirectional mode.
    acc_before = acc_cnt;
    for (int i = 0; i < 30; i++) vclk_pulse();
    check(acc_cnt == acc_before, "R8", "no fetch in bidirectional mode", acc_cnt, acc_before);
    check(bidir_mode == 1, "R8", "mode sticky", bidir_mode, 1);
    check(sda_oe == 0, "R8", "line released", sda_oe, 0);

    // Reset returns to transmit-only; a long bclk low then switches mode.
    reset_and_check();
    for (int i = 0; i < SYNCE + 5 * 9; i++) vclk_pulse();
    bclk_in = 0;
    repeat (60) @(negedge clk);
    check(bidir_mode == 1, "R7", "long bclk low enters mode", bidir_mode, 1);
    bclk_in = 1;
    for (int i = 0; i < 5; i++) vclk_pulse();
    check(sda_oe == 0, "R8", "line released after entry", sda_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run incomplete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule